// File: doc/BRIEF.md
# Paired 32-bit timer with coherent holding register

This block holds two 16-bit up-counters that can run as two independent timers or be joined into one 32-bit timer. Software reaches them over a narrow 16-bit register port with an address, write data, write strobe, read strobe and registered read data. A mode input picks independent or joined operation. A count-enable input advances the counters by one on every clock edge where it is high. A 32-bit period input sets where each count wraps back to zero, and a sticky match flag records each wrap.

In joined mode a 16-bit holding register makes each 32-bit access look atomic. Reading the low half captures the high half into the holding register on the same edge. Software then reads the high half from the holding register. To write, software stages the high half in the holding register, and the later low-half write loads both counters on one edge. In independent mode the holding register is frozen and each counter is accessed directly.

Address map (2-bit address): 0 = low counter, 1 = high counter, 2 = holding register, 3 = match flags (bit 0 = low or joined timer, bit 1 = high timer in independent mode; all other read bits are zero).

Top module: `pair_timer32`

## Requirements
- R1: In joined mode, a read of address 0 copies the high counter into the holding register on that clock edge, so that a following read of address 2 returns the high half that belongs with the low half just read.
- R2: In joined mode, address 1 is not the way to the high half. A read of it returns 0x0000 and a write to it changes nothing.
- R3: In joined mode, a write to address 2 sets the holding register and leaves both counters unchanged.
- R4: In joined mode, a write to address 0 loads the low counter with the write data and, on the same edge, loads the high counter from the holding register.
- R5: In independent mode, addresses 0 and 1 read and write the low and high counters directly. The holding register ignores writes and keeps its value, and a read of address 2 returns 0x0000.
- R6: In joined mode with counting enabled, the high counter increments only on the edge where the low counter wraps from 0xFFFF to 0x0000.
- R7: When counting is enabled and the joined count equals the period value, the next edge clears both counters and sets flag bit 0. The flag stays set until a write to address 3 with data bit 0 = 1; a write with that bit 0 leaves it set.
- R8: A write to the low counter on an edge where counting is enabled loads exactly the written value, with no increment on that edge.
- R9: A read of address 0 returns the low count as it was before that edge's increment, and the captured high half matches that same moment, even across a carry.
- R10: In independent mode each counter wraps separately against its own 16-bit half of the period: low against bits 15:0 (setting flag bit 0), high against bits 31:16 (setting flag bit 1). The low counter's wrap does not carry into the high counter.
- R11: After reset the counters, holding register, flags and read data are zero. Read data appears on the clock edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode32 | input | 1 | 1 = joined 32-bit timer, 0 = two independent 16-bit timers |
| cnt_en | input | 1 | Count one per edge while high |
| tmr_period | input | 32 | Wrap value (joined), or two 16-bit wrap values |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| match_flag | output | 2 | Sticky wrap flags (bit 0 low/joined, bit 1 high) |

## Verification
The hardest case to reach from the ports is a low-half read that lands on the very edge where the low counter carries into the high counter. If the design captured the value after the increment, the two halves would disagree by a full 65536 counts. The stimulus stages a high half, writes 0xFFFF into the low half, and then raises count enable and the read strobe on the same cycle. The read data must show 0xFFFF, the holding register must show the old high half, and a later read must show the carried value. A second delicate case is a low-half write made while counting is enabled, which must land without an extra increment.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] A_HOLD = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd3;
  localparam int unsigned FLAG_W = 2;
endpackage

// File: rtl/ptmr_half.sv
module ptmr_half #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         at_max
);
  // load beats wrap, wrap beats increment
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
  end

  assign at_max = &q;

  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(ld_val)); // R8
endmodule

// File: rtl/ptmr_hold.sv
module ptmr_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic         snap,
  input  logic [W-1:0] sval,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (en) begin
      if (wr)        q <= wval;
      else if (snap) q <= sval;
    end
  end

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !en |=> q == $past(q)); // R5
endmodule

// File: rtl/ptmr_rdmux.sv
module ptmr_rdmux #(
  parameter int unsigned W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd,
  input  logic [ptmr_pkg::ADDR_W-1:0]  addr,
  input  logic                         mode32,
  input  logic [W-1:0]                 lo,
  input  logic [W-1:0]                 hi,
  input  logic [W-1:0]                 hold,
  input  logic [ptmr_pkg::FLAG_W-1:0]  flags,
  output logic [W-1:0]                 rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    case (addr)
      ptmr_pkg::A_LO:   sel = lo;
      ptmr_pkg::A_HI:   sel = mode32 ? '0 : hi;
      ptmr_pkg::A_HOLD: sel = mode32 ? hold : '0;
      default:          sel = {{(W-ptmr_pkg::FLAG_W){1'b0}}, flags};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R11
endmodule

// File: rtl/pair_timer32.sv
module pair_timer32 #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         mode32,
  input  logic                         cnt_en,
  input  logic [2*HALF_W-1:0]          tmr_period,
  input  logic [ptmr_pkg::ADDR_W-1:0]  reg_addr,
  input  logic [HALF_W-1:0]            reg_wdata,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  output logic [HALF_W-1:0]            reg_rdata,
  output logic [ptmr_pkg::FLAG_W-1:0]  match_flag
);
  localparam int unsigned FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_q, hi_q, hold_q;
  logic              lo_max, hi_max_unused;
  logic              wr_lo, wr_hi, wr_hold, wr_flag, rd_lo;
  logic              full_eq, lo_eq, hi_eq;
  logic              lo_clr, hi_clr, hi_inc, hi_ld;
  logic [HALF_W-1:0] hi_ld_val;
  logic [ptmr_pkg::FLAG_W-1:0] flag_set, flag_q;

  assign wr_lo   = reg_wr && reg_addr == ptmr_pkg::A_LO;
  assign wr_hi   = reg_wr && reg_addr == ptmr_pkg::A_HI;
  assign wr_hold = reg_wr && reg_addr == ptmr_pkg::A_HOLD;
  assign wr_flag = reg_wr && reg_addr == ptmr_pkg::A_FLAG;
  assign rd_lo   = reg_rd && reg_addr == ptmr_pkg::A_LO;

  assign full_eq = {hi_q, lo_q} == tmr_period;
  assign lo_eq   = lo_q == tmr_period[HALF_W-1:0];
  assign hi_eq   = hi_q == tmr_period[FULL_W-1:HALF_W];

  assign lo_clr    = cnt_en && (mode32 ? full_eq : lo_eq);
  assign hi_clr    = cnt_en && (mode32 ? full_eq : hi_eq);
  assign hi_inc    = cnt_en && (mode32 ? lo_max : 1'b1);
  assign hi_ld     = mode32 ? wr_lo : wr_hi;
  assign hi_ld_val = mode32 ? hold_q : reg_wdata;

  assign flag_set[0] = lo_clr;
  assign flag_set[1] = cnt_en && !mode32 && hi_eq;

  ptmr_half #(.W(HALF_W)) u_lo (
    .clk(clk), .rst(rst), .ld(wr_lo), .ld_val(reg_wdata),
    .clr(lo_clr), .inc(cnt_en), .q(lo_q), .at_max(lo_max)
  );

  ptmr_half #(.W(HALF_W)) u_hi (
    .clk(clk), .rst(rst), .ld(hi_ld), .ld_val(hi_ld_val),
    .clr(hi_clr), .inc(hi_inc), .q(hi_q), .at_max(hi_max_unused)
  );

  ptmr_hold #(.W(HALF_W)) u_hold (
    .clk(clk), .rst(rst), .en(mode32), .wr(wr_hold), .wval(reg_wdata),
    .snap(rd_lo), .sval(hi_q), .q(hold_q)
  );

  // sticky flags: a set on the same edge as a clear wins
  for (genvar i = 0; i < int'(ptmr_pkg::FLAG_W); i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flag_q[i] <= 1'b0;
      else if (flag_set[i]) flag_q[i] <= 1'b1;
      else if (wr_flag && reg_wdata[i]) flag_q[i] <= 1'b0;
    end
  end
  assign match_flag = flag_q;

  ptmr_rdmux #(.W(HALF_W)) u_rd (
    .clk(clk), .rst(rst), .rd(reg_rd), .addr(reg_addr), .mode32(mode32),
    .lo(lo_q), .hi(hi_q), .hold(hold_q), .flags(flag_q), .rdata(reg_rdata)
  );

  AST_SNAP_ON_LO_READ: assert property (@(posedge clk) disable iff (rst)
    mode32 && rd_lo |=> hold_q == $past(hi_q)); // R1
  AST_HI_ADDR_INERT: assert property (@(posedge clk) disable iff (rst)
    mode32 && wr_hi && !cnt_en |=> hi_q == $past(hi_q)); // R2
  AST_HOLD_WR_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    mode32 && wr_hold && !cnt_en |=> $stable(lo_q) && $stable(hi_q)); // R3
  AST_LO_WR_COMMIT: assert property (@(posedge clk) disable iff (rst)
    mode32 && wr_lo |=> lo_q == $past(reg_wdata) && hi_q == $past(hold_q)); // R4
  AST_CARRY_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    mode32 && cnt_en && !wr_lo && !full_eq && lo_max
      |=> lo_q == '0 && hi_q == HALF_W'($past(hi_q) + 1'b1)); // R6
  AST_NO_CARRY_MIDWAY: assert property (@(posedge clk) disable iff (rst)
    mode32 && cnt_en && !wr_lo && !lo_max |=> $stable(hi_q) || hi_q == '0); // R6
  AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (rst)
    mode32 && cnt_en && full_eq && !wr_lo
      |=> lo_q == '0 && hi_q == '0 && match_flag[0]); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    match_flag[0] && !(wr_flag && reg_wdata[0]) |=> match_flag[0]); // R7
  AST_READ_PRE_INC: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> reg_rdata == $past(lo_q)); // R9
  AST_SPLIT_HI_WRAP: assert property (@(posedge clk) disable iff (rst)
    !mode32 && cnt_en && hi_eq && !wr_hi |=> hi_q == '0 && match_flag[1]); // R10
endmodule

// File: tb/sim_pair_timer32.sv
module sim_pair_timer32;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode32 = 1'b0;
  logic          cnt_en = 1'b0;
  logic [2*W-1:0] tmr_period = 32'hFFFF_FFFF;
  logic [1:0]    reg_addr = 2'd0;
  logic [W-1:0]  reg_wdata = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [W-1:0]  reg_rdata;
  logic [1:0]    match_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  sb_item_t sbq[$];
  logic launched = 1'b0;

  pair_timer32 #(.HALF_W(W)) u0 (
    .clk(clk), .rst(rst), .mode32(mode32), .cnt_en(cnt_en),
    .tmr_period(tmr_period), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .match_flag(match_flag)
  );

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) launched <= reg_rd;
  always @(negedge clk) begin
    if (launched) begin
      if (sbq.size() == 0) check(1'b0, "scoreboard empty", reg_rdata, '0);
      else begin
        sb_item_t it;
        it = sbq.pop_front();
        check(reg_rdata == it.exp, it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%h expected=%h", 1'b0, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    sb_item_t it;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(reg_rdata == '0, "R11 rdata after reset", reg_rdata, '0);
    check(match_flag == 2'b00, "R11 flags after reset", {14'b0, match_flag}, '0);
    rd(2'd0, 16'h0000, "R11 low after reset");

    // R5 independent access
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'hABCD);
    rd(2'd0, 16'h1234, "R5 low direct");
    rd(2'd1, 16'hABCD, "R5 high direct");
    wr(2'd2, 16'h5555);
    rd(2'd2, 16'h0000, "R5 hold reads zero in split mode");

    // joined mode
    @(negedge clk); mode32 = 1'b1;
    rd(2'd2, 16'h0000, "R5 hold ignored split-mode write");
    rd(2'd1, 16'h0000, "R2 high address reads zero");
    wr(2'd1, 16'h7777);
    wr(2'd2, 16'h0002);
    rd(2'd0, 16'h1234, "R3 low unchanged by hold write");
    rd(2'd2, 16'hABCD, "R1 R2 R3 snapshot of untouched high");

    // R4 coherent write
    wr(2'd2, 16'h0007);
    wr(2'd0, 16'hFFFE);
    rd(2'd0, 16'hFFFE, "R4 low loaded");
    rd(2'd2, 16'h0007, "R4 high committed from hold");

    // R6 carry
    run(3);
    rd(2'd0, 16'h0001, "R6 low after wrap");
    rd(2'd2, 16'h0008, "R6 high carried once");

    // R8 write while counting
    wr(2'd2, 16'h0000);
    @(negedge clk);
    cnt_en = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0100; reg_wr = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0; reg_wr = 1'b0;
    rd(2'd0, 16'h0100, "R8 written value exact");
    rd(2'd2, 16'h0000, "R8 high from hold");

    // R9 read on the carry edge
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'hFFFF);
    @(negedge clk);
    cnt_en = 1'b1; reg_addr = 2'd0; reg_rd = 1'b1;
    it.exp = 16'hFFFF; it.tag = "R9 low pre-increment";
    sbq.push_back(it);
    @(negedge clk);
    cnt_en = 1'b0; reg_rd = 1'b0;
    rd(2'd2, 16'h0005, "R9 snapshot before carry");
    rd(2'd0, 16'h0000, "R9 low after carry");
    rd(2'd2, 16'h0006, "R9 R6 high after carry");

    // R7 joined period match
    @(negedge clk); tmr_period = 32'h0002_0003;
    wr(2'd2, 16'h0002);
    wr(2'd0, 16'h0001);
    run(2);
    check(match_flag == 2'b00, "R7 no flag before match", {14'b0, match_flag}, 16'h0);
    run(1);
    check(match_flag == 2'b01, "R7 flag on match wrap", {14'b0, match_flag}, 16'h1);
    run(2);
    rd(2'd0, 16'h0002, "R7 low restarted from zero");
    rd(2'd2, 16'h0000, "R7 high cleared on wrap");
    rd(2'd3, 16'h0001, "R7 flag readable");
    wr(2'd3, 16'h0000);
    check(match_flag == 2'b01, "R7 zero write keeps flag", {14'b0, match_flag}, 16'h1);
    wr(2'd3, 16'h0001);
    check(match_flag == 2'b00, "R7 flag cleared", {14'b0, match_flag}, 16'h0);

    // R10 independent wraps
    @(negedge clk); mode32 = 1'b0; tmr_period = 32'h0010_0004;
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h0010);
    run(2);
    rd(2'd0, 16'h0000, "R10 low wrapped on own period");
    rd(2'd1, 16'h0001, "R10 high wrapped separately");
    check(match_flag == 2'b11, "R10 both flags", {14'b0, match_flag}, 16'h3);

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "scoreboard drained", 16'(sbq.size()), 16'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule